// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block is the front end of a small 64-bit processor whose instructions are one to ten bytes long. In each cycle the fetch logic gives it the program counter and a ten-byte window of instruction memory that starts at that address. The block splits the leading specifier byte into an instruction code and a function code. It picks out the two register nibbles and the little-endian constant word when the instruction carries them. It also works out how many bytes the instruction uses and the address of the next instruction in sequence.

The specifier byte alone decides where each field sits and how long the instruction is. Instruction codes that are not defined, and function codes outside a family's range, raise an invalid-instruction flag. An optional add-immediate instruction (code 0xC) is decoded only when a build parameter enables it. All results come out of one output register, so a downstream stage sees a stable, fully decoded record one cycle after it presents the window.

Top module: `fdec_top`

## Requirements
- R1: The high nibble of window byte 0 is reported as the instruction code and the low nibble as the function code.
- R2: Instruction lengths in bytes: codes 0x0, 0x1 and 0x9 take 1; codes 0x2, 0x6, 0xA and 0xB take 2; codes 0x7 and 0x8 take 9; codes 0x3, 0x4, 0x5 and 0xC take 10.
- R3: The sequential PC output equals the input PC plus the instruction length, modulo 2^64.
- R4: For codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA, 0xB and 0xC, register A is the high nibble and register B the low nibble of window byte 1. For every other code, and for invalid instructions, both are 0xF (no register).
- R5: The constant is eight bytes taken little-endian. It starts at window byte 1 for codes 0x7 and 0x8 and at window byte 2 for codes 0x3, 0x4, 0x5 and 0xC. It is zero for every other instruction.
- R6: The function code must be 0..3 for code 0x6, 0..6 for codes 0x2 and 0x7, and 0 for every other defined code. Any other value makes the instruction invalid.
- R7: Codes 0xD, 0xE and 0xF are invalid. Code 0xC is invalid when the add-immediate option is disabled.
- R8: An invalid instruction reports length 1, no register byte, no constant, both registers 0xF, a zero constant, and PC plus 1 as the sequential PC.
- R9: Every result appears one clock after the window is sampled with the input valid high. The output valid follows the input valid with that same delay. Reset clears every output to zero.
- R10: The register-byte flag is high exactly for the codes listed in R4, and the constant flag exactly for the codes listed in R5, when the instruction is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and PC are meaningful this cycle |
| pc_in | input | 64 | Address of window byte 0 |
| win_in | input | 80 | Instruction bytes; byte k is bits 8k+7..8k |
| out_valid | output | 1 | Decoded record is valid |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| reg_a | output | 4 | First register field |
| reg_b | output | 4 | Second register field |
| const_w | output | 64 | Constant word |
| ins_len | output | 4 | Instruction length in bytes |
| seq_pc | output | 64 | Address of the next sequential instruction |
| has_regs | output | 1 | A register byte is present |
| has_const | output | 1 | A constant word is present |
| bad_instr | output | 1 | Invalid instruction |

## Verification
Every decoded field, the length, the flags and the sequential PC pass through a single register stage. Each of them is therefore due exactly one rising edge after the cycle in which the window is driven. The bench drives the window on a falling edge and reads the results on the next falling edge, which leaves exactly one rising edge in between. The output valid is checked the same way, one edge after the input valid is dropped. A second instance built without the add-immediate option gets the same stimulus, and its invalid flag is read in that same cycle.

// File: rtl/fdec_pkg.sv
package fdec_pkg;

   localparam int LEN_W = 4;

   typedef enum logic [3:0] {
      IC_HALT  = 4'h0,
      IC_NOP   = 4'h1,
      IC_CMOV  = 4'h2,
      IC_IRMOV = 4'h3,
      IC_RMMOV = 4'h4,
      IC_MRMOV = 4'h5,
      IC_ALU   = 4'h6,
      IC_JMP   = 4'h7,
      IC_CALL  = 4'h8,
      IC_RET   = 4'h9,
      IC_PUSH  = 4'hA,
      IC_POP   = 4'hB,
      IC_IADD  = 4'hC
   } icode_e;

   localparam logic [3:0] REG_NONE  = 4'hF;
   localparam logic [3:0] ALU_FMAX  = 4'h3;
   localparam logic [3:0] COND_FMAX = 4'h6;

   typedef struct packed {
      logic             ok;
      logic             need_regs;
      logic             need_const;
      logic [LEN_W-1:0] len;
   } dec_info_t;

endpackage

// File: rtl/fdec_classify.sv
module fdec_classify
   import fdec_pkg::*;
#(
   parameter int  CONST_BYTES = 8,
   parameter bit  EN_IADD     = 1'b1
) (
   input  logic [3:0] ic,
   input  logic [3:0] fn,
   output dec_info_t  info
);

   localparam logic [LEN_W-1:0] CB = LEN_W'(CONST_BYTES);

   logic ok_raw, nr_raw, nc_raw;

   always_comb begin
      ok_raw = 1'b0;
      nr_raw = 1'b0;
      nc_raw = 1'b0;
      case (ic)
         IC_HALT, IC_NOP, IC_RET: begin
            ok_raw = (fn == 4'h0);
         end
         IC_CMOV: begin
            ok_raw = (fn <= COND_FMAX);
            nr_raw = 1'b1;
         end
         IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
            ok_raw = (fn == 4'h0);
            nr_raw = 1'b1;
            nc_raw = 1'b1;
         end
         IC_ALU: begin
            ok_raw = (fn <= ALU_FMAX);
            nr_raw = 1'b1;
         end
         IC_JMP: begin
            ok_raw = (fn <= COND_FMAX);
            nc_raw = 1'b1;
         end
         IC_CALL: begin
            ok_raw = (fn == 4'h0);
            nc_raw = 1'b1;
         end
         IC_PUSH, IC_POP: begin
            ok_raw = (fn == 4'h0);
            nr_raw = 1'b1;
         end
         IC_IADD: begin
            ok_raw = EN_IADD && (fn == 4'h0);
            nr_raw = 1'b1;
            nc_raw = 1'b1;
         end
         default: begin
            ok_raw = 1'b0;
         end
      endcase
   end

   always_comb begin
      info.ok         = ok_raw;
      info.need_regs  = ok_raw & nr_raw;
      info.need_const = ok_raw & nc_raw;
      info.len        = LEN_W'(1)
                      + (info.need_regs  ? LEN_W'(1) : '0)
                      + (info.need_const ? CB        : '0);
   end

endmodule

// File: rtl/fdec_fields.sv
module fdec_fields
   import fdec_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int WIN_BYTES = 10
) (
   input  logic [8*(WIN_BYTES-1)-1:0] tail,
   input  logic                       need_regs,
   input  logic                       need_const,
   output logic [3:0]                 ra,
   output logic [3:0]                 rb,
   output logic [WORD_W-1:0]          valc
);

   localparam int CB = WORD_W / 8;

   logic [WORD_W-1:0] c_near;
   logic [WORD_W-1:0] c_far;

   for (genvar k = 0; k < CB; k++) begin : g_byte
      assign c_near[8*k +: 8] = tail[8*k +: 8];
      assign c_far[8*k +: 8]  = tail[8*(k+1) +: 8];
   end

   always_comb begin
      ra   = need_regs ? tail[7:4] : REG_NONE;
      rb   = need_regs ? tail[3:0] : REG_NONE;
      valc = '0;
      if (need_const) begin
         valc = need_regs ? c_far : c_near;
      end
   end

endmodule

// File: rtl/fdec_seqpc.sv
module fdec_seqpc
   import fdec_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W-1:0] npc
);

   assign npc = pc + ADDR_W'(len);

endmodule

// File: rtl/fdec_top.sv
module fdec_top
   import fdec_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int WORD_W    = 64,
   parameter int WIN_BYTES = 10,
   parameter bit EN_IADD   = 1'b1,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [ADDR_W-1:0]      pc_in,
   input  logic [8*WIN_BYTES-1:0] win_in,
   output logic                   out_valid,
   output logic [3:0]             icode,
   output logic [3:0]             ifun,
   output logic [3:0]             reg_a,
   output logic [3:0]             reg_b,
   output logic [WORD_W-1:0]      const_w,
   output logic [LEN_W-1:0]       ins_len,
   output logic [ADDR_W-1:0]      seq_pc,
   output logic                   has_regs,
   output logic                   has_const,
   output logic                   bad_instr
);

   localparam int CONST_BYTES = WORD_W / 8;
   localparam int MAX_LEN     = 2 + CONST_BYTES;

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("fdec_top: WORD_W must be a whole number of bytes");
   end
   if (WIN_BYTES != MAX_LEN) begin : g_chk_win
      $error("fdec_top: WIN_BYTES must equal the longest instruction");
   end
   if (MAX_LEN > (1 << LEN_W) - 1) begin : g_chk_len
      $error("fdec_top: instruction length does not fit the length field");
   end
   if (ADDR_W < 8) begin : g_chk_addr
      $error("fdec_top: ADDR_W too narrow");
   end

   dec_info_t         info;
   logic [3:0]        ra_c, rb_c;
   logic [WORD_W-1:0] valc_c;
   logic [ADDR_W-1:0] npc_c;

   fdec_classify #(
      .CONST_BYTES (CONST_BYTES),
      .EN_IADD     (EN_IADD)
   ) u_cls (
      .ic   (win_in[7:4]),
      .fn   (win_in[3:0]),
      .info (info)
   );

   fdec_fields #(
      .WORD_W    (WORD_W),
      .WIN_BYTES (WIN_BYTES)
   ) u_fld (
      .tail       (win_in[8*WIN_BYTES-1:8]),
      .need_regs  (info.need_regs),
      .need_const (info.need_const),
      .ra         (ra_c),
      .rb         (rb_c),
      .valc       (valc_c)
   );

   fdec_seqpc #(
      .ADDR_W (ADDR_W)
   ) u_pc (
      .pc  (pc_in),
      .len (info.len),
      .npc (npc_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            icode     <= '0;
            ifun      <= '0;
            reg_a     <= '0;
            reg_b     <= '0;
            const_w   <= '0;
            ins_len   <= '0;
            seq_pc    <= '0;
            has_regs  <= 1'b0;
            has_const <= 1'b0;
            bad_instr <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               icode     <= win_in[7:4];
               ifun      <= win_in[3:0];
               reg_a     <= ra_c;
               reg_b     <= rb_c;
               const_w   <= valc_c;
               ins_len   <= info.len;
               seq_pc    <= npc_c;
               has_regs  <= info.need_regs;
               has_const <= info.need_const;
               bad_instr <= ~info.ok;
            end
         end
      end

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid) else $error("valid not forwarded"); // R9
      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid) else $error("spurious valid"); // R9
      AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (ins_len >= LEN_W'(1) && ins_len <= LEN_W'(MAX_LEN)))
         else $error("length out of range"); // R2
      AST_NEXT_PC: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (seq_pc == $past(pc_in) + ADDR_W'(ins_len)))
         else $error("sequential pc mismatch"); // R3
      AST_NO_REG_NONE: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !has_regs) |-> (reg_a == REG_NONE && reg_b == REG_NONE))
         else $error("register field without register byte"); // R4
      AST_NO_CONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !has_const) |-> (const_w == '0))
         else $error("constant without constant word"); // R5
      AST_BAD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && bad_instr) |-> (ins_len == LEN_W'(1) && !has_regs && !has_const))
         else $error("invalid instruction not collapsed"); // R8
      AST_UNDEF_BAD: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && icode >= 4'hD) |-> bad_instr)
         else $error("undefined code accepted"); // R7
   end else begin : g_comb
      always_comb begin
         out_valid = in_valid;
         icode     = win_in[7:4];
         ifun      = win_in[3:0];
         reg_a     = ra_c;
         reg_b     = rb_c;
         const_w   = valc_c;
         ins_len   = info.len;
         seq_pc    = npc_c;
         has_regs  = info.need_regs;
         has_const = info.need_const;
         bad_instr = ~info.ok;
      end
   end

endmodule

// File: tb/sim_fdec_top.sv
module sim_fdec_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [63:0] pc_in = '0;
   logic [79:0] win_in = '0;

   logic        out_valid, has_regs, has_const, bad_instr;
   logic [3:0]  icode, ifun, reg_a, reg_b, ins_len;
   logic [63:0] const_w, seq_pc;

   logic        v1, hr1, hc1, bad1;
   logic [3:0]  ic1, fn1, ra1, rb1, len1;
   logic [63:0] c1, sp1;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_P/2) clk = ~clk;

   fdec_top u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in), .win_in(win_in),
      .out_valid(out_valid), .icode(icode), .ifun(ifun), .reg_a(reg_a), .reg_b(reg_b),
      .const_w(const_w), .ins_len(ins_len), .seq_pc(seq_pc), .has_regs(has_regs),
      .has_const(has_const), .bad_instr(bad_instr)
   );

   fdec_top #(.EN_IADD(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_in(pc_in), .win_in(win_in),
      .out_valid(v1), .icode(ic1), .ifun(fn1), .reg_a(ra1), .reg_b(rb1),
      .const_w(c1), .ins_len(len1), .seq_pc(sp1), .has_regs(hr1),
      .has_const(hc1), .bad_instr(bad1)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [79:0] mk_win(input logic [7:0] b0, input logic [7:0] b1,
                                          input logic [63:0] c, input int off);
      logic [79:0] w;
      w = '0;
      w[7:0]  = b0;
      w[15:8] = b1;
      for (int k = 0; k < 8; k++) w[8*(off+k) +: 8] = c[8*k +: 8];
      return w;
   endfunction

   // Expected decode from the requirement tables (R2, R4, R5, R6, R7)
   task automatic ref_dec(input logic [3:0] ic, input logic [3:0] fn, input bit iadd,
                          output bit ok, output bit nr, output bit nc);
      ok = 1'b0; nr = 1'b0; nc = 1'b0;
      case (ic)
         4'h0, 4'h1, 4'h9: ok = (fn == 0);
         4'h2:             begin ok = (fn <= 6); nr = 1; end
         4'h3, 4'h4, 4'h5: begin ok = (fn == 0); nr = 1; nc = 1; end
         4'h6:             begin ok = (fn <= 3); nr = 1; end
         4'h7:             begin ok = (fn <= 6); nc = 1; end
         4'h8:             begin ok = (fn == 0); nc = 1; end
         4'hA, 4'hB:       begin ok = (fn == 0); nr = 1; end
         4'hC:             begin ok = iadd && (fn == 0); nr = 1; nc = 1; end
         default:          ok = 1'b0;
      endcase
      if (!ok) begin nr = 0; nc = 0; end
   endtask

   task automatic run_insn(input logic [63:0] pc, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [63:0] c, input string req);
      bit ok, nr, nc, ok1, nr1, nc1;
      int len, off;
      ref_dec(b0[7:4], b0[3:0], 1'b1, ok, nr, nc);
      ref_dec(b0[7:4], b0[3:0], 1'b0, ok1, nr1, nc1);
      len = 1 + (nr ? 1 : 0) + (nc ? 8 : 0);
      off = nr ? 2 : 1;
      @(negedge clk);
      in_valid = 1'b1;
      pc_in    = pc;
      win_in   = nc ? mk_win(b0, b1, c, off) : mk_win(b0, b1, c, 2);
      @(negedge clk);
      chk("R9",  "out_valid", 64'(out_valid), 64'd1);
      chk("R1",  "icode",     64'(icode), 64'(b0[7:4]));
      chk("R1",  "ifun",      64'(ifun),  64'(b0[3:0]));
      chk(req,   "bad_instr", 64'(bad_instr), 64'(!ok));
      chk("R2",  "ins_len",   64'(ins_len), 64'(len));
      chk("R3",  "seq_pc",    seq_pc, pc + 64'(len));
      chk("R10", "has_regs",  64'(has_regs), 64'(nr));
      chk("R10", "has_const", 64'(has_const), 64'(nc));
      chk("R4",  "reg_a",     64'(reg_a), nr ? 64'(b1[7:4]) : 64'hF);
      chk("R4",  "reg_b",     64'(reg_b), nr ? 64'(b1[3:0]) : 64'hF);
      chk("R5",  "const_w",   const_w, nc ? c : 64'd0);
      chk("R7",  "bad_instr no-iadd build", 64'(bad1), 64'(!ok1));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9", "reset out_valid", 64'(out_valid), 64'd0);
      chk("R9", "reset seq_pc",    seq_pc, 64'd0);
      chk("R9", "reset ins_len",   64'(ins_len), 64'd0);
      chk("R9", "reset const_w",   const_w, 64'd0);
   endtask

   task automatic t_all_codes;
      for (int i = 0; i < 16; i++)
         run_insn(64'h1000 + 64'(i), {4'(i), 4'h0}, 8'h3C, 64'h0102030405060708, "R7");
   endtask

   task automatic t_fields;
      run_insn(64'h40, 8'h30, 8'hF2, 64'hDEADBEEF_CAFEF00D, "R5");
      run_insn(64'h50, 8'h40, 8'h71, 64'h8000000000000001, "R5");
      run_insn(64'h60, 8'h73, 8'h00, 64'h0011223344556677, "R5");
      run_insn(64'h70, 8'h80, 8'h00, 64'hFFEEDDCCBBAA9988, "R5");
      run_insn(64'h80, 8'h61, 8'h9A, 64'h5555AAAA5555AAAA, "R4");
      run_insn(64'h90, 8'hC0, 8'h0E, 64'h0000000000000010, "R4");
   endtask

   task automatic t_funcs;
      for (int f = 0; f < 16; f++) begin
         run_insn(64'h200, {4'h6, 4'(f)}, 8'h12, 64'h1, "R6");
         run_insn(64'h300, {4'h7, 4'(f)}, 8'h00, 64'h2, "R6");
         run_insn(64'h400, {4'h2, 4'(f)}, 8'h45, 64'h3, "R6");
      end
      run_insn(64'h500, 8'h91, 8'h00, 64'h4, "R6");
      run_insn(64'h500, 8'hA5, 8'h00, 64'h4, "R6");
   endtask

   task automatic t_invalid;
      run_insn(64'hABC0, 8'hE7, 8'h12, 64'h99, "R8");
      run_insn(64'hABD0, 8'h3F, 8'h12, 64'h99, "R8");
   endtask

   task automatic t_wrap;
      run_insn(64'hFFFF_FFFF_FFFF_FFFA, 8'h50, 8'h12, 64'h7, "R3");
      run_insn(64'hFFFF_FFFF_FFFF_FFFF, 8'h10, 8'h00, 64'h7, "R3");
   endtask

   task automatic t_idle;
      @(negedge clk);
      in_valid = 1'b0;
      win_in   = mk_win(8'h30, 8'h11, 64'h1234, 2);
      @(negedge clk);
      chk("R9", "idle out_valid", 64'(out_valid), 64'd0);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog R9: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_all_codes();
      t_fields();
      t_funcs();
      t_invalid();
      t_wrap();
      t_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule